// File: doc/BRIEF.md
# DS3 Far-End Block Error Code Generator

This block chooses the 3-bit far-end block error code that the transmit framer places in every outbound DS3 frame. A byte-wide control register, written and read back by the host, selects between two modes: a forced mode, in which each outbound frame carries a 3-bit value taken straight from the register, and an automatic mode, in which the code reflects the health of frames seen by the companion receive framer.

In automatic mode the receive framer reports, on its end-of-frame strobe, whether that frame had framing-bit, multiframe-bit or path-parity (CP) errors. Each errored received frame is queued in a small saturating counter. At every transmit start-of-frame strobe the block hands over one code for the new frame with a one-cycle valid strobe. The code is 000 if an errored frame is pending, which also consumes one queued entry. Otherwise it is 111, the clean code.

Control changes never disturb a frame in flight. The code for a frame is decided only at its start-of-frame strobe and then held.

Top module: `febe_gen`

## Requirements
- R1: After reset the control register reads 0x00, which selects automatic mode, the code output is 111, and the valid strobe is low.
- R2: A write stores all 8 bits, and the read data shows the written byte from the cycle after the write onward. Bits 3 to 0 (the parity-error control and the 3-bit mask) are only stored and read back; they never change the code.
- R3: The register layout is: bits 7 to 5 hold the forced code, and bit 4 is the force enable (1 = forced mode, 0 = automatic mode).
- R4: The code output changes only in the cycle after a transmit start-of-frame strobe. A register write between strobes leaves the code unchanged until the next strobe, which uses the register value held at that strobe.
- R5: One cycle after each transmit start-of-frame strobe, the valid strobe is high for exactly one cycle, and the new code is present in that same cycle.
- R6: In forced mode every frame carries bits 7 to 5 of the register, whatever errors are pending.
- R7: In automatic mode with no errored frame pending, the frame carries 111.
- R8: A received end-of-frame strobe with any of the F, M or CP error flags set counts as one errored frame, and the next transmit frame in automatic mode carries 000. Error flags without an end-of-frame strobe are ignored.
- R9: Each pending errored frame yields exactly one 000 frame. The pending count saturates at 7, so 7 frames of 000 follow, then 111.
- R10: An errored end-of-frame that arrives in the same cycle as a transmit start-of-frame is not reflected in that frame; it is carried into the next one.
- R11: Every start-of-frame strobe consumes one pending errored frame, in forced mode too, so errors seen while forced are not replayed after a return to automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_f_err | input | 1 | Framing-bit error flag for the received frame |
| rx_m_err | input | 1 | Multiframe-bit error flag for the received frame |
| rx_cp_err | input | 1 | Path-parity (CP) error flag for the received frame |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| febe_code | output | 3 | Code for the current outbound frame |
| febe_valid | output | 1 | One-cycle strobe marking a newly latched code |

## Verification
The embedded assertions check the rules that hold on every cycle:
- the valid strobe follows each start-of-frame strobe and no other cycle;
- the code stays stable between strobes;
- forced mode copies the register field;
- an empty queue in automatic mode gives 111;
- the pending count holds at its ceiling;
- a write reads back.

Only the bench scenarios can show the counting behaviour over many frames: one 000 per errored frame, draining after saturation, the same-cycle deferral, the mode switches that flush the queue, and the rule that error flags without an end-of-frame strobe are dropped.

// File: rtl/febe_pkg.sv
package febe_pkg;
    localparam int CFG_W  = 8;
    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_CLEAN  = '1;
    localparam logic [CODE_W-1:0] CODE_ERRORED = '0;

    typedef struct packed {
        logic [CODE_W-1:0] forced_code;
        logic              force_en;
        logic              pbit_ctl;
        logic [2:0]        mbit_mask;
    } cfg_t;
endpackage

// File: rtl/febe_cfg_reg.sv
module febe_cfg_reg
    import febe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.cfg = cfg_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg == cfg_t'($past(wdata))));
endmodule

// File: rtl/febe_err_acc.sv
module febe_err_acc #(
    parameter int MAX_PEND = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_ev,
    input  logic take,
    output logic pending
);
    localparam int CNT_W = $clog2(MAX_PEND + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PEND);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   dec;

    always_comb begin
        st_d = st_q;
        dec  = take && (st_q.cnt != '0);
        if (dec && !err_ev)
            st_d.cnt = st_q.cnt - 1'b1;
        else if (err_ev && !dec && (st_q.cnt != CNT_MAX))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = (st_q.cnt != '0);

    // R9: the count holds at its ceiling when more errors arrive
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && err_ev && !take) |=> (st_q.cnt == CNT_MAX));
    // R11: a strobe always consumes one pending entry
    a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !err_ev && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/febe_code_sel.sv
module febe_code_sel
    import febe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_sof,
    input  logic              force_en,
    input  logic [CODE_W-1:0] forced_code,
    input  logic              pending,
    output logic [CODE_W-1:0] code,
    output logic              valid
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = tx_sof;
        if (tx_sof) begin
            if (force_en)     st_d.code = forced_code;
            else if (pending) st_d.code = CODE_ERRORED;
            else              st_d.code = CODE_CLEAN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code  <= CODE_CLEAN;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code  = st_q.code;
    assign valid = st_q.valid;

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sof |=> $stable(code));
endmodule

// File: rtl/febe_gen.sv
module febe_gen
    import febe_pkg::*;
#(
    parameter int MAX_PEND = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              rx_eof,
    input  logic              rx_f_err,
    input  logic              rx_m_err,
    input  logic              rx_cp_err,
    input  logic              tx_sof,
    output logic [CODE_W-1:0] febe_code,
    output logic              febe_valid
);
    cfg_t cfg;
    logic err_ev;
    logic pending;

    assign err_ev    = rx_eof && (rx_f_err || rx_m_err || rx_cp_err);
    assign cfg_rdata = CFG_W'(cfg);

    febe_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    febe_err_acc #(.MAX_PEND(MAX_PEND)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_ev  (err_ev),
        .take    (tx_sof),
        .pending (pending)
    );

    febe_code_sel i_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_sof      (tx_sof),
        .force_en    (cfg.force_en),
        .forced_code (cfg.forced_code),
        .pending     (pending),
        .code        (febe_code),
        .valid       (febe_valid)
    );

    a_r5_valid_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof |=> febe_valid);
    a_r5_valid_only_sof: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sof |=> !febe_valid);
    a_r6_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && cfg_rdata[4]) |=> (febe_code == $past(cfg_rdata[7:5])));
    a_r7_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof && !cfg_rdata[4] && !pending) |=> (febe_code == 3'b111));
endmodule

// File: tb/test_febe_gen.sv
module test_febe_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rx_eof = 1'b0, rx_f_err = 1'b0, rx_m_err = 1'b0, rx_cp_err = 1'b0;
    logic       tx_sof = 1'b0;
    logic [2:0] febe_code;
    logic       febe_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    febe_gen i_febe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_eof(rx_eof), .rx_f_err(rx_f_err),
        .rx_m_err(rx_m_err), .rx_cp_err(rx_cp_err), .tx_sof(tx_sof),
        .febe_code(febe_code), .febe_valid(febe_valid)
    );

    // Vector: {write flag, write byte, errored rx frames, expected code}
    localparam int NVEC = 12;
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 4'd0, 3'b111},
        {1'b0, 8'h00, 4'd1, 3'b000},
        {1'b0, 8'h00, 4'd0, 3'b111},
        {1'b0, 8'h00, 4'd2, 3'b000},
        {1'b0, 8'h00, 4'd0, 3'b000},
        {1'b0, 8'h00, 4'd0, 3'b111},
        {1'b1, 8'hB0, 4'd1, 3'b101},
        {1'b0, 8'h00, 4'd0, 3'b101},
        {1'b1, 8'h00, 4'd0, 3'b111},
        {1'b1, 8'hF0, 4'd0, 3'b111},
        {1'b1, 8'h10, 4'd0, 3'b000},
        {1'b1, 8'h00, 4'd1, 3'b000}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rx_err(input int kind);
        @(negedge clk);
        rx_eof = 1'b1;
        rx_f_err = (kind % 3 == 0); rx_m_err = (kind % 3 == 1); rx_cp_err = (kind % 3 == 2);
        @(negedge clk);
        rx_eof = 1'b0; rx_f_err = 1'b0; rx_m_err = 1'b0; rx_cp_err = 1'b0;
    endtask

    // pulse SOF, then check code and valid in the cycle after it, then valid drop
    task automatic sof_check(input logic [2:0] exp, input string req);
        @(negedge clk); tx_sof = 1'b1;
        @(negedge clk); tx_sof = 1'b0;
        check(febe_valid === 1'b1, "R5 valid", int'(febe_valid), 1);
        check(febe_code === exp, req, int'(febe_code), int'(exp));
        @(negedge clk);
        check(febe_valid === 1'b0, "R5 pulse width", int'(febe_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata === 8'h00, "R1 rdata", int'(cfg_rdata), 0);
        check(febe_code === 3'b111, "R1 code", int'(febe_code), 7);
        check(febe_valid === 1'b0, "R1 valid", int'(febe_valid), 0);

        // Table walk: R3 R6 R7 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][15]) wr(VEC[i][14:7]);
            for (int k = 0; k < int'(VEC[i][6:3]); k++) rx_err(i + k);
            sof_check(VEC[i][2:0], $sformatf("R6/R7/R8/R11 vec %0d", i));
        end

        // R2 readback including stored-only bits; they do not change the code
        wr(8'h0F);
        check(cfg_rdata === 8'h0F, "R2 readback", int'(cfg_rdata), 8'h0F);
        sof_check(3'b111, "R2 low bits no effect");

        // R8 flags without end-of-frame are ignored
        @(negedge clk); rx_f_err = 1'b1; rx_m_err = 1'b1; rx_cp_err = 1'b1;
        @(negedge clk); rx_f_err = 1'b0; rx_m_err = 1'b0; rx_cp_err = 1'b0;
        sof_check(3'b111, "R8 no eof ignored");

        // R4 write mid-frame does not move the code until the next strobe
        wr(8'hB0);
        check(cfg_rdata === 8'hB0, "R2 readback mid-frame", int'(cfg_rdata), 8'hB0);
        repeat (3) @(negedge clk);
        check(febe_code === 3'b111, "R4 code held", int'(febe_code), 7);
        sof_check(3'b101, "R4 new value at strobe");
        wr(8'h00);

        // R9 saturation: 9 errored frames give 7 errored codes then clean
        for (int k = 0; k < 9; k++) rx_err(k);
        for (int k = 0; k < 7; k++) sof_check(3'b000, "R9 queued errored");
        sof_check(3'b111, "R9 saturated drain");

        // R10 errored eof in same cycle as SOF goes to next frame
        @(negedge clk); tx_sof = 1'b1; rx_eof = 1'b1; rx_cp_err = 1'b1;
        @(negedge clk); tx_sof = 1'b0; rx_eof = 1'b0; rx_cp_err = 1'b0;
        check(febe_code === 3'b111, "R10 same-cycle frame", int'(febe_code), 7);
        sof_check(3'b000, "R10 deferred errored");
        sof_check(3'b111, "R10 then clean");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule